// File: doc/BRIEF.md
# Flash Command Register Decoder

This block is the bus-side command interpreter of a byte-wide electrically erasable flash memory. Each write cycle on the host bus delivers one byte to a command register. The decoder uses these bytes to step through the program and erase sequences: setup, a timed operation, and a verify step in which the host reads back the byte under margin conditions. At the same time it chooses what a read cycle returns and which address the array sees.

The decoder models no charge physics, margin voltages or analog timing. It hands single-cycle start and stop strobes, the latched address and the program data to a behavioural array model, and that model does the real work. One enable input stands in for high-voltage supply sensing. While that input is low, every write is dropped and the device can only be read.

The normal program flow is: write 40h, write the data byte at the target address, then write C0h to end the pulse and verify. Bytes may go to any address in any order. The erase flow is: write 20h twice, then write A0h with the address to verify. Two FFh writes after a setup command cancel the sequence.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and after reset is asserted in the middle of any sequence, the decoder is in array-read mode. All four strobes are low, `arr_raddr` follows `rd_addr`, `bus_rdata` carries `arr_rdata`, and the next write is decoded as a command.
- R2: A write made while `vpp_en` is low changes nothing. No strobe fires, the mode stays the same, and the byte is not treated as a command.
- R3: In program setup (entered with 40h), a write of any byte other than FFh latches that byte and its address. `pgm_start` then pulses for exactly one cycle, starting in the cycle after the write, and `pgm_addr` and `pgm_data` hold the latched values.
- R4: Writing C0h while a program pulse runs raises `pgm_stop` for one cycle and enters program-verify. The write address is not latched. In verify, `arr_raddr` is the last programmed address and `bus_rdata` carries `arr_mrgn_rdata`.
- R5: Writing 20h in erase setup (entered with 20h) pulses `ers_start`. Writing A0h while the erase runs pulses `ers_stop`, latches the write address and enters erase-verify. Further A0h writes in erase-verify latch a new address and fire no strobe.
- R6: Two consecutive FFh writes after a setup command return the decoder to array-read with no start strobe. After a single FFh, any other byte is decoded as a fresh command.
- R7: 00h and any unrecognised code return the decoder to array-read. C0h and A0h written outside a running pulse do not enter verify. Erase setup followed by any byte other than 20h or FFh returns to array-read without erasing.
- R8: Any write other than C0h during a program pulse, and any write other than A0h during an erase pulse, raises the matching stop strobe and returns to array-read.
- R9: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vpp_en | input | 1 | High-voltage enable; writes are accepted only while it is high |
| wr_en | input | 1 | One-cycle write strobe; marks the end of a bus write |
| wr_addr | input | AW | Address of the write |
| wr_data | input | 8 | Command or program data byte |
| rd_addr | input | AW | Host read address |
| bus_rdata | output | 8 | Data returned to the host read cycle |
| arr_raddr | output | AW | Read address given to the array model |
| arr_rdata | input | 8 | Normal read data from the array model |
| arr_mrgn_rdata | input | 8 | Margin read data from the array model |
| pgm_start | output | 1 | Program pulse begins (one cycle) |
| pgm_stop | output | 1 | Program pulse ends (one cycle) |
| ers_start | output | 1 | Erase pulse begins (one cycle) |
| ers_stop | output | 1 | Erase pulse ends (one cycle) |
| pgm_addr | output | AW | Latched program or erase-verify address |
| pgm_data | output | 8 | Latched program data |

## Verification
The bench builds the decoder with `AW` = 8. This lets an 8-bit address and an 8-bit data value sit side by side in each table row, and lets the bench model both array read ports as simple XOR patterns of the address, so normal data and margin data always differ. With these values the table covers every transition: aborts, a single FFh followed by a new command, ignored writes with `vpp_en` low, and stray writes during a pulse. Directed tests then cover reset in the middle of a pulse and a setup state that is interrupted by a low enable.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] OP_READ  = 8'h00;
  localparam logic [DW-1:0] OP_PSET  = 8'h40;
  localparam logic [DW-1:0] OP_ESET  = 8'h20;
  localparam logic [DW-1:0] OP_PVFY  = 8'hC0;
  localparam logic [DW-1:0] OP_EVFY  = 8'hA0;
  localparam logic [DW-1:0] OP_ABORT = 8'hFF;

  typedef enum logic [2:0] {
    ST_READ, ST_PSET, ST_PRUN, ST_PVFY,
    ST_ESET, ST_ERUN, ST_EVFY, ST_ABRT
  } st_e;

  typedef struct packed {
    logic pstart;
    logic pstop;
    logic estart;
    logic estop;
  } strb_t;
endpackage

// File: rtl/fcr_cmd_fsm.sv
module fcr_cmd_fsm
  import fcr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vpp_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output st_e           st_q,
  output strb_t         sb_q,
  output logic          ld_prog,
  output logic          ld_vaddr
);
  st_e   st_d;
  strb_t sb_d;
  logic  wr_ok;

  assign wr_ok = wr_en & vpp_en;

  function automatic st_e base_decode(input logic [DW-1:0] b);
    if (b == OP_PSET)      return ST_PSET;
    else if (b == OP_ESET) return ST_ESET;
    else                   return ST_READ;
  endfunction

  always_comb begin
    st_d     = st_q;
    sb_d     = '0;
    ld_prog  = 1'b0;
    ld_vaddr = 1'b0;
    if (wr_ok) begin
      case (st_q)
        ST_PSET: begin
          if (wr_data == OP_ABORT) st_d = ST_ABRT;
          else begin
            st_d        = ST_PRUN;
            sb_d.pstart = 1'b1;
            ld_prog     = 1'b1;
          end
        end
        ST_ESET: begin
          if (wr_data == OP_ESET) begin
            st_d        = ST_ERUN;
            sb_d.estart = 1'b1;
          end else if (wr_data == OP_ABORT) st_d = ST_ABRT;
          else st_d = ST_READ;
        end
        ST_PRUN: begin
          sb_d.pstop = 1'b1;
          st_d       = (wr_data == OP_PVFY) ? ST_PVFY : ST_READ;
        end
        ST_ERUN: begin
          sb_d.estop = 1'b1;
          if (wr_data == OP_EVFY) begin
            st_d     = ST_EVFY;
            ld_vaddr = 1'b1;
          end else st_d = ST_READ;
        end
        ST_ABRT: st_d = (wr_data == OP_ABORT) ? ST_READ : base_decode(wr_data);
        ST_EVFY: begin
          if (wr_data == OP_EVFY) ld_vaddr = 1'b1;
          else st_d = base_decode(wr_data);
        end
        default: st_d = base_decode(wr_data);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_READ;
      sb_q <= '0;
    end else begin
      st_q <= st_d;
      sb_q <= sb_d;
    end
  end

  // R3
  pstart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_q.pstart |-> ($past(st_q) == ST_PSET) && (st_q == ST_PRUN));
  // R4
  pstop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_q.pstop |-> ($past(st_q) == ST_PRUN));
  // R2
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_en |=> $stable(st_q) && (sb_q == '0));
  // R6
  abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ABRT) |=> !sb_q.pstart && !sb_q.estart);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sb_q));
endmodule

// File: rtl/fcr_addr_latch.sv
module fcr_addr_latch #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_prog,
  input  logic          ld_vaddr,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_data
);
  logic addr_en;
  assign addr_en = ld_prog | ld_vaddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_addr <= '0;
    else if (addr_en) lat_addr <= wr_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_data <= '0;
    else if (ld_prog) lat_data <= wr_data;
  end
endmodule

// File: rtl/fcr_read_mux.sv
module fcr_read_mux
  import fcr_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  st_e           st_q,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] lat_addr,
  input  logic [DW-1:0] arr_rdata,
  input  logic [DW-1:0] arr_mrgn_rdata,
  output logic [AW-1:0] arr_raddr,
  output logic [DW-1:0] bus_rdata
);
  logic vfy;
  assign vfy       = (st_q == ST_PVFY) || (st_q == ST_EVFY);
  assign arr_raddr = vfy ? lat_addr : rd_addr;
  assign bus_rdata = vfy ? arr_mrgn_rdata : arr_rdata;

  // R4
  vaddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PVFY) && ($past(st_q) == ST_PVFY) |-> $stable(arr_raddr));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcr_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vpp_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] arr_raddr,
  input  logic [DW-1:0] arr_rdata,
  input  logic [DW-1:0] arr_mrgn_rdata,
  output logic          pgm_start,
  output logic          pgm_stop,
  output logic          ers_start,
  output logic          ers_stop,
  output logic [AW-1:0] pgm_addr,
  output logic [DW-1:0] pgm_data
);
  logic [1:0] rsync_q;
  logic       rst_q;
  st_e        st_q;
  strb_t      sb_q;
  logic       ld_prog, ld_vaddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  fcr_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_q), .vpp_en(vpp_en), .wr_en(wr_en),
    .wr_data(wr_data), .st_q(st_q), .sb_q(sb_q),
    .ld_prog(ld_prog), .ld_vaddr(ld_vaddr)
  );

  fcr_addr_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_q), .ld_prog(ld_prog), .ld_vaddr(ld_vaddr),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .lat_addr(pgm_addr), .lat_data(pgm_data)
  );

  fcr_read_mux #(.AW(AW)) u_rmux (
    .clk(clk), .rst_n(rst_q), .st_q(st_q), .rd_addr(rd_addr),
    .lat_addr(pgm_addr), .arr_rdata(arr_rdata),
    .arr_mrgn_rdata(arr_mrgn_rdata), .arr_raddr(arr_raddr),
    .bus_rdata(bus_rdata)
  );

  assign pgm_start = sb_q.pstart;
  assign pgm_stop  = sb_q.pstop;
  assign ers_start = sb_q.estart;
  assign ers_stop  = sb_q.estop;
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  localparam int AW = 8;
  localparam int NV = 39;
  localparam logic [7:0] RA = 8'h33;

  logic clk = 1'b0;
  logic rst_n, vpp_en, wr_en;
  logic [AW-1:0] wr_addr, rd_addr, arr_raddr, pgm_addr;
  logic [7:0] wr_data, bus_rdata, arr_rdata, arr_mrgn_rdata, pgm_data;
  logic pgm_start, pgm_stop, ers_start, ers_stop;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  assign arr_rdata      = arr_raddr ^ 8'h5A;
  assign arr_mrgn_rdata = arr_raddr ^ 8'hA5;

  flash_cmd_decoder #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .bus_rdata(bus_rdata), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .arr_mrgn_rdata(arr_mrgn_rdata), .pgm_start(pgm_start),
    .pgm_stop(pgm_stop), .ers_start(ers_start), .ers_stop(ers_stop),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data)
  );

  // row: {req, wr, vpp, data, addr, strobes{ps,pp,es,ep}, margin, raddr}
  localparam logic [34:0] VEC [NV] = '{
    {4'd3, 1'b1, 1'b1, 8'h40, 8'h00, 4'b0000, 1'b0, RA},    // R3 setup
    {4'd3, 1'b1, 1'b1, 8'h5C, 8'h12, 4'b1000, 1'b0, RA},    // R3 data
    {4'd3, 1'b0, 1'b1, 8'h00, 8'h00, 4'b0000, 1'b0, RA},    // R3 one cycle
    {4'd4, 1'b1, 1'b1, 8'hC0, 8'h99, 4'b0100, 1'b1, 8'h12}, // R4 no relatch
    {4'd4, 1'b0, 1'b1, 8'h00, 8'h00, 4'b0000, 1'b1, 8'h12}, // R4
    {4'd3, 1'b1, 1'b1, 8'h40, 8'h00, 4'b0000, 1'b0, RA},    // R3
    {4'd3, 1'b1, 1'b1, 8'h00, 8'h07, 4'b1000, 1'b0, RA},    // R3 random addr
    {4'd4, 1'b1, 1'b1, 8'hC0, 8'h00, 4'b0100, 1'b1, 8'h07}, // R4
    {4'd7, 1'b1, 1'b1, 8'h00, 8'h00, 4'b0000, 1'b0, RA},    // R7 read
    {4'd5, 1'b1, 1'b1, 8'h20, 8'h00, 4'b0000, 1'b0, RA},    // R5
    {4'd5, 1'b1, 1'b1, 8'h20, 8'h00, 4'b0010, 1'b0, RA},    // R5 erase start
    {4'd5, 1'b1, 1'b1, 8'hA0, 8'h04, 4'b0001, 1'b1, 8'h04}, // R5 verify
    {4'd5, 1'b1, 1'b1, 8'hA0, 8'h05, 4'b0000, 1'b1, 8'h05}, // R5 relatch
    {4'd7, 1'b1, 1'b1, 8'h00, 8'h00, 4'b0000, 1'b0, RA},    // R7
    {4'd6, 1'b1, 1'b1, 8'h40, 8'h00, 4'b0000, 1'b0, RA},    // R6
    {4'd6, 1'b1, 1'b1, 8'hFF, 8'h00, 4'b0000, 1'b0, RA},    // R6
    {4'd6, 1'b1, 1'b1, 8'hFF, 8'h00, 4'b0000, 1'b0, RA},    // R6 aborted
    {4'd7, 1'b1, 1'b1, 8'h5C, 8'h12, 4'b0000, 1'b0, RA},    // R7 needs command
    {4'd6, 1'b1, 1'b1, 8'h20, 8'h00, 4'b0000, 1'b0, RA},    // R6
    {4'd6, 1'b1, 1'b1, 8'hFF, 8'h00, 4'b0000, 1'b0, RA},    // R6
    {4'd6, 1'b1, 1'b1, 8'hFF, 8'h00, 4'b0000, 1'b0, RA},    // R6
    {4'd2, 1'b1, 1'b0, 8'h40, 8'h00, 4'b0000, 1'b0, RA},    // R2 ignored
    {4'd2, 1'b1, 1'b1, 8'h12, 8'h01, 4'b0000, 1'b0, RA},    // R2 still read
    {4'd3, 1'b1, 1'b1, 8'h40, 8'h00, 4'b0000, 1'b0, RA},    // R3
    {4'd3, 1'b1, 1'b1, 8'h20, 8'h09, 4'b1000, 1'b0, RA},    // R3 code as data
    {4'd8, 1'b1, 1'b1, 8'h55, 8'h00, 4'b0100, 1'b0, RA},    // R8 stray write
    {4'd8, 1'b0, 1'b1, 8'h00, 8'h00, 4'b0000, 1'b0, RA},    // R8
    {4'd7, 1'b1, 1'b1, 8'h20, 8'h00, 4'b0000, 1'b0, RA},    // R7
    {4'd7, 1'b1, 1'b1, 8'h77, 8'h00, 4'b0000, 1'b0, RA},    // R7 bad confirm
    {4'd7, 1'b1, 1'b1, 8'h20, 8'h00, 4'b0000, 1'b0, RA},    // R7 no erase
    {4'd6, 1'b1, 1'b1, 8'hFF, 8'h00, 4'b0000, 1'b0, RA},    // R6 single FF
    {4'd6, 1'b1, 1'b1, 8'h40, 8'h00, 4'b0000, 1'b0, RA},    // R6 new command
    {4'd3, 1'b1, 1'b1, 8'h6A, 8'h0E, 4'b1000, 1'b0, RA},    // R3
    {4'd4, 1'b1, 1'b1, 8'hC0, 8'h00, 4'b0100, 1'b1, 8'h0E}, // R4
    {4'd7, 1'b1, 1'b1, 8'h00, 8'h00, 4'b0000, 1'b0, RA},    // R7
    {4'd5, 1'b1, 1'b1, 8'h20, 8'h00, 4'b0000, 1'b0, RA},    // R5
    {4'd5, 1'b1, 1'b1, 8'h20, 8'h00, 4'b0010, 1'b0, RA},    // R5
    {4'd8, 1'b1, 1'b1, 8'h33, 8'h00, 4'b0001, 1'b0, RA},    // R8 erase stray
    {4'd7, 1'b1, 1'b1, 8'hA0, 8'h00, 4'b0000, 1'b0, RA}     // R7 no verify
  };

  task automatic check_out(input int req, input logic [3:0] es,
                           input logic mg, input logic [7:0] ra);
    logic [3:0] as;
    logic [7:0] eb;
    as = {pgm_start, pgm_stop, ers_start, ers_stop};
    eb = mg ? (ra ^ 8'hA5) : (ra ^ 8'h5A);
    nchk++;
    if (as !== es || arr_raddr !== ra || bus_rdata !== eb) begin
      nfail++;
      $display("FAIL R%0d: strobes %b raddr %h rdata %h, expected %b %h %h",
               req, as, arr_raddr, bus_rdata, es, ra, eb);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [7:0] a, input logic v);
    wr_en = 1'b1; wr_data = d; wr_addr = a; vpp_en = v;
    @(negedge clk);
    wr_en = 1'b0; vpp_en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; vpp_en = 1'b1; wr_en = 1'b0;
    wr_data = '0; wr_addr = '0; rd_addr = RA;
    repeat (3) @(negedge clk);
    check_out(1, 4'b0000, 1'b0, RA);  // R1 reset state
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out(1, 4'b0000, 1'b0, RA);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i][30]; vpp_en = VEC[i][29];
      wr_data = VEC[i][28:21]; wr_addr = VEC[i][20:13];
      @(negedge clk);
      check_out(int'(VEC[i][34:31]), VEC[i][12:9], VEC[i][8], VEC[i][7:0]);
    end
    wr_en = 1'b0; vpp_en = 1'b1;

    // R3: latched address and data travel with the start strobe
    wr(8'h40, 8'h00, 1'b1);
    wr(8'h3C, 8'h2B, 1'b1);
    nchk++;
    if (pgm_addr !== 8'h2B || pgm_data !== 8'h3C) begin
      nfail++;
      $display("FAIL R3: pgm_addr %h pgm_data %h, expected 2b 3c", pgm_addr, pgm_data);
    end

    // R1: reset during a program pulse, next byte is a command
    #1 rst_n = 1'b0;
    #1 check_out(1, 4'b0000, 1'b0, RA);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h6A, 8'h01, 1'b1);
    check_out(1, 4'b0000, 1'b0, RA);

    // R2: low enable in program setup leaves setup pending
    wr(8'h40, 8'h00, 1'b1);
    wr(8'h11, 8'h02, 1'b0);
    check_out(2, 4'b0000, 1'b0, RA);
    wr(8'h11, 8'h02, 1'b1);
    check_out(2, 4'b1000, 1'b0, RA);
    wr(8'hC0, 8'h00, 1'b1);
    check_out(4, 4'b0100, 1'b1, 8'h02);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: run did not end, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule